// File: doc/BRIEF.md
# Write Clock Phase Generator

This block sits in a data slice of a memory PHY. Once per controller clock it takes a phased enable vector and a phased two-bit mode vector, with one entry for each phase of the controller-to-PHY ratio. It turns them into a parallel pattern of write-clock bits, one bit per fast-clock tick, which a downstream serializer shifts out. The write clock runs at two or four times the command clock. Each controller phase therefore owns two or four consecutive ticks of the pattern.

Each tick is produced by a four-state waveform machine. The machine tracks the current output level and whether the first or second tick at that level has been spent. Its states are `WS_LO_FIRST`, `WS_LO_SECOND`, `WS_HI_FIRST` and `WS_HI_SECOND`.

The transitions depend on the tick's mode:
- **Toggle** walks LO_FIRST → LO_SECOND → HI_FIRST → HI_SECOND → LO_FIRST.
- **Fast toggle** jumps from either low state to HI_FIRST and from either high state to LO_FIRST.
- **Static low, static high and disabled** ticks send the machine to LO_FIRST.
- **Unused tick slots** leave the state where it is.

The machine is chained through every tick of a cycle. It is registered between cycles, so a run of toggling phases forms one continuous waveform.

Top module: `wck_phase_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `pattern_o` is all zero, and the waveform state is `WS_LO_FIRST`, so the first toggling tick after reset is low.
- R2: The pattern computed from the inputs sampled at one rising clock edge appears on `pattern_o` right after that edge and stays unchanged until the next edge.
- R3: With the phase enabled, mode code 00 (static low) gives 0 on all of that phase's ticks and mode code 01 (static high) gives 1 on all of them.
- R4: With a phase's enable bit at 0, all of its ticks are 0 whatever its mode code is.
- R5: Mode code 10 (toggle) holds each level for exactly two ticks and then inverts it.
- R6: Mode code 11 (fast toggle) inverts the level on every tick.
- R7: The waveform state carries across phase boundaries and across controller cycles, so consecutive toggling ticks continue without a restart.
- R8: A disabled, static-low or static-high tick resets the waveform, so the next toggling tick starts low, in its first tick.
- R9: `ratio_code` sets the number of phases in use: 00 gives 1, 01 gives 2, and 10 or 11 gives 4. Phase p tick t is bit p*M+t of `pattern_o`, where M is the multiplier. Bits at and above (phases × M) are 0.
- R10: `mult_hi` = 0 gives M = 2 ticks per phase and `mult_hi` = 1 gives M = 4 ticks per phase.
- R11: Switching between toggle and fast toggle keeps the current level: the first tick in the new mode repeats the level the previous mode left.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_code | input | 2 | Phase-count select (00:1, 01:2, else 4) |
| mult_hi | input | 1 | Fast-clock multiplier select (0: x2, 1: x4) |
| phase_en | input | 4 | Per-phase write-clock enable, bit p for phase p |
| phase_mode | input | 8 | Per-phase mode, bits [2p+1:2p] for phase p |
| pattern_o | output | 16 | Registered tick pattern, bit 0 leaves first |

## Verification
The main function is tried with uniform runs of each mode (static low, static high, toggle, fast toggle), which separate the level-holding behaviour of each code. Directed sequences cover several cases: toggle runs interrupted by a disabled or static phase, which show that the waveform restarts; toggle-to-fast switches, which show that the level is kept; and a disabled sweep over every mode code, which shows that the mode is ignored. A near-exhaustive sweep then runs mixed per-phase codes over all six ratio and multiplier combinations. This sweep exposes wrong tick ordering, wrong phase decoding, wrong bits used in the unused region and any break in continuity at phase and cycle boundaries. Every output sample is also compared just before the next edge, to confirm the one-cycle latency.

// File: rtl/wck_gen_pkg.sv
package wck_gen_pkg;

    typedef enum logic [1:0] {
        WM_STATIC_LO = 2'b00,
        WM_STATIC_HI = 2'b01,
        WM_TOGGLE    = 2'b10,
        WM_FAST      = 2'b11
    } wck_mode_e;

    typedef enum logic [1:0] {
        WS_LO_FIRST  = 2'b00,
        WS_LO_SECOND = 2'b01,
        WS_HI_FIRST  = 2'b10,
        WS_HI_SECOND = 2'b11
    } wave_state_e;

    // number of controller phases in use for a ratio code
    function automatic int unsigned phases_of(input logic [1:0] rc);
        unique case (rc)
            2'b00:   return 1;
            2'b01:   return 2;
            default: return 4;
        endcase
    endfunction

endpackage

// File: rtl/wck_phase_map.sv
module wck_phase_map
    import wck_gen_pkg::*;
#(
    parameter int MAX_PH = 4,
    parameter int MUL_LO = 2,
    parameter int MUL_HI = 4,
    localparam int TICKS = MAX_PH * MUL_HI
) (
    input  logic [1:0]          ratio_code,
    input  logic                mult_hi,
    input  logic [MAX_PH-1:0]   phase_en,
    input  logic [2*MAX_PH-1:0] phase_mode,
    output logic [TICKS-1:0]    tick_act,
    output logic [TICKS-1:0]    tick_en,
    output logic [2*TICKS-1:0]  tick_mode
);

    int unsigned n_ph;
    assign n_ph = phases_of(ratio_code);

    for (genvar k = 0; k < TICKS; k++) begin : g_tick
        localparam int PH_HI = k / MUL_HI;
        localparam int PH_LO = k / MUL_LO;
        logic       lo_act, lo_en, hi_act, hi_en;
        logic [1:0] lo_mode, hi_mode;

        assign hi_act  = (PH_HI < n_ph);
        assign hi_en   = phase_en[PH_HI];
        assign hi_mode = phase_mode[2*PH_HI +: 2];

        if (PH_LO < MAX_PH) begin : g_lo
            assign lo_act  = (PH_LO < n_ph);
            assign lo_en   = phase_en[PH_LO];
            assign lo_mode = phase_mode[2*PH_LO +: 2];
        end else begin : g_lo_none
            assign lo_act  = 1'b0;
            assign lo_en   = 1'b0;
            assign lo_mode = 2'b00;
        end

        always_comb begin
            if (mult_hi) begin
                tick_act[k]        = hi_act;
                tick_en[k]         = hi_en;
                tick_mode[2*k +: 2] = hi_mode;
            end else begin
                tick_act[k]        = lo_act;
                tick_en[k]         = lo_en;
                tick_mode[2*k +: 2] = lo_mode;
            end
        end
    end

endmodule

// File: rtl/wck_tick_step.sv
module wck_tick_step
    import wck_gen_pkg::*;
(
    input  logic        act,
    input  logic        en,
    input  logic [1:0]  mode,
    input  wave_state_e cur,
    output wave_state_e nxt,
    output logic        bit_o
);

    logic level_hi;
    assign level_hi = (cur == WS_HI_FIRST) || (cur == WS_HI_SECOND);

    always_comb begin
        nxt   = cur;
        bit_o = 1'b0;
        if (act) begin
            if (!en) begin
                nxt = WS_LO_FIRST;
            end else begin
                unique case (wck_mode_e'(mode))
                    WM_STATIC_LO: begin
                        bit_o = 1'b0;
                        nxt   = WS_LO_FIRST;
                    end
                    WM_STATIC_HI: begin
                        bit_o = 1'b1;
                        nxt   = WS_LO_FIRST;
                    end
                    WM_TOGGLE: begin
                        bit_o = level_hi;
                        unique case (cur)
                            WS_LO_FIRST:  nxt = WS_LO_SECOND;
                            WS_LO_SECOND: nxt = WS_HI_FIRST;
                            WS_HI_FIRST:  nxt = WS_HI_SECOND;
                            WS_HI_SECOND: nxt = WS_LO_FIRST;
                        endcase
                    end
                    WM_FAST: begin
                        bit_o = level_hi;
                        nxt   = level_hi ? WS_LO_FIRST : WS_HI_FIRST;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/wck_phase_gen.sv
module wck_phase_gen
    import wck_gen_pkg::*;
#(
    parameter int MAX_PH = 4,
    parameter int MUL_LO = 2,
    parameter int MUL_HI = 4,
    localparam int TICKS = MAX_PH * MUL_HI
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          ratio_code,
    input  logic                mult_hi,
    input  logic [MAX_PH-1:0]   phase_en,
    input  logic [2*MAX_PH-1:0] phase_mode,
    output logic [TICKS-1:0]    pattern_o
);

    logic [TICKS-1:0]   tick_act, tick_en, tick_bits;
    logic [2*TICKS-1:0] tick_mode;
    wave_state_e        wave_q;
    wave_state_e        chain [TICKS+1];

    wck_phase_map #(
        .MAX_PH (MAX_PH),
        .MUL_LO (MUL_LO),
        .MUL_HI (MUL_HI)
    ) i_map (
        .ratio_code (ratio_code),
        .mult_hi    (mult_hi),
        .phase_en   (phase_en),
        .phase_mode (phase_mode),
        .tick_act   (tick_act),
        .tick_en    (tick_en),
        .tick_mode  (tick_mode)
    );

    assign chain[0] = wave_q;

    for (genvar k = 0; k < TICKS; k++) begin : g_step
        wck_tick_step i_step (
            .act   (tick_act[k]),
            .en    (tick_en[k]),
            .mode  (tick_mode[2*k +: 2]),
            .cur   (chain[k]),
            .nxt   (chain[k+1]),
            .bit_o (tick_bits[k])
        );
    end

    // waveform state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wave_q <= WS_LO_FIRST;
        else        wave_q <= chain[TICKS];
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pattern_o <= '0;
        else        pattern_o <= tick_bits;
    end

    // ---------------- assertions ----------------
    logic [TICKS-1:0] used_mask;
    always_comb begin
        used_mask = '0;
        for (int k = 0; k < TICKS; k++)
            if (k < int'(phases_of(ratio_code)) * (mult_hi ? MUL_HI : MUL_LO))
                used_mask[k] = 1'b1;
    end

    p_reset_zero_r1: assert property (@(posedge clk)
        !rst_n |=> (pattern_o == '0));

    p_unused_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pattern_o & ~$past(used_mask)) == '0));

    p_disabled_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_en == '0) |=> (pattern_o == '0));

    p_static_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((&phase_en) && (phase_mode == {MAX_PH{2'b01}}))
        |=> (pattern_o == $past(used_mask)));

    p_fast_alt_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((&phase_en) && (phase_mode == {MAX_PH{2'b11}}))
        |=> (((pattern_o ^ (pattern_o >> 1)) & ($past(used_mask) >> 1))
             == ($past(used_mask) >> 1)));

endmodule

// File: tb/test_wck_phase_gen.sv
module test_wck_phase_gen;

    localparam int PH = 4;
    localparam int TK = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      ratio_code = 2'b00;
    logic            mult_hi = 1'b0;
    logic [PH-1:0]   en = '0;
    logic [2*PH-1:0] mode = '0;
    logic [TK-1:0]   pattern;

    int n_cmp = 0;
    int n_bad = 0;
    int m_lvl = 0;
    int m_cnt = 0;
    logic [TK-1:0] exp_q = '0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    wck_phase_gen i_wck_phase_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .ratio_code (ratio_code),
        .mult_hi    (mult_hi),
        .phase_en   (en),
        .phase_mode (mode),
        .pattern_o  (pattern)
    );

    task automatic check(input string tag, input logic [TK-1:0] act, input logic [TK-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: rc=%0d mh=%0d got %h expected %h", tag, ratio_code, mult_hi, act, exp);
        end
    endtask

    // reference model built from the requirements
    task automatic model(input logic [PH-1:0] e, input logic [2*PH-1:0] md);
        int nph, m;
        logic [TK-1:0] r;
        nph = (ratio_code == 2'b00) ? 1 : (ratio_code == 2'b01) ? 2 : 4;
        m   = mult_hi ? 4 : 2;
        r   = '0;
        for (int k = 0; k < nph * m; k++) begin
            int p;
            int c;
            p = k / m;
            c = int'(md[2*p +: 2]);
            if (!e[p] || c < 2) begin
                r[k]  = e[p] && (c == 1);
                m_lvl = 0;
                m_cnt = 0;
            end else begin
                r[k] = (m_lvl != 0);
                if (c == 3) begin
                    m_lvl = 1 - m_lvl;
                    m_cnt = 0;
                end else if (m_cnt == 1) begin
                    m_lvl = 1 - m_lvl;
                    m_cnt = 0;
                end else begin
                    m_cnt = 1;
                end
            end
        end
        exp_q = r;
    endtask

    // called at a falling edge: drive, confirm hold, clock, check
    task automatic step(input string tag, input logic [PH-1:0] e, input logic [2*PH-1:0] md);
        en   = e;
        mode = md;
        #1;
        check("R2", pattern, exp_q);
        model(e, md);
        @(posedge clk);
        @(negedge clk);
        check(tag, pattern, exp_q);
    endtask

    function automatic logic [2*PH-1:0] all_md(input logic [1:0] c);
        return {PH{c}};
    endfunction

    task automatic run_config(input logic [1:0] rc, input logic mh);
        logic [TK-1:0] full;
        int nb;
        @(negedge clk);
        rst_n = 1'b0;
        en = '0;
        mode = '0;
        ratio_code = rc;
        mult_hi = mh;
        @(negedge clk);
        check("R1", pattern, '0);
        @(negedge clk);
        rst_n = 1'b1;
        m_lvl = 0;
        m_cnt = 0;
        exp_q = '0;
        #1;
        check("R1", pattern, '0);
        // first toggle run after reset starts low
        step("R1", '1, all_md(2'b10));
        step("R5", '1, all_md(2'b10));
        step("R5", '1, all_md(2'b10));
        step("R7", '1, all_md(2'b10));
        // static levels and phase/multiplier decode
        nb   = ((rc == 2'b00) ? 1 : (rc == 2'b01) ? 2 : 4) * (mh ? 4 : 2);
        full = (nb >= TK) ? '1 : ((TK'(1) << nb) - TK'(1));
        step("R3", '1, all_md(2'b01));
        check(mh ? "R10" : "R9", pattern, full);
        step("R3", '1, all_md(2'b00));
        // disabled: mode ignored
        for (int c = 0; c < 4; c++) step("R4", '0, all_md(c[1:0]));
        // fast toggle run
        for (int i = 0; i < 3; i++) step("R6", '1, all_md(2'b11));
        // restart after disable and after static
        step("R8", '1, all_md(2'b10));
        step("R8", '1, 8'b10_10_10_10 & {PH{2'b11}});
        step("R8", 4'b1110, all_md(2'b10));
        step("R8", '1, all_md(2'b10));
        step("R8", '1, 8'b10_10_01_10);
        step("R8", '1, all_md(2'b10));
        // toggle/fast switch keeps level
        step("R11", '1, 8'b11_10_11_10);
        step("R11", '1, 8'b10_11_10_11);
        step("R11", '1, all_md(2'b11));
        step("R11", '1, all_md(2'b10));
        // near-exhaustive mixed sweep of per-phase codes
        for (int c = 0; c < 96; c++) begin
            logic [PH-1:0]   e;
            logic [2*PH-1:0] md;
            for (int p = 0; p < PH; p++) begin
                int code;
                code = ((c + p * 3) ^ (c >> 3)) & 7;
                e[p] = (code != 1);
                md[2*p +: 2] = code[1:0];
            end
            step("R7", e, md);
        end
    endtask

    initial begin
        for (int rc = 0; rc < 3; rc++)
            for (int mh = 0; mh < 2; mh++)
                run_config(rc[1:0], mh[0]);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #3000000;
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, got timeout expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule